// File: doc/BRIEF.md
# Serial Control and Diagnostic Port for an Eight-Channel Output Controller

This block is the slave side of a four-wire serial link for an eight-channel output controller. The serial clock, the active-low chip enable and the serial data input are oversampled on a fast system clock. Each frame brings in one command byte and sends out one diagnostic byte. The diagnostic byte is captured from the channel status inputs when the chip enable falls.

When the chip enable rises, the command byte is copied into the output control register. This happens only if the frame held a whole, nonzero number of bytes. Any other frame leaves the register as it was and raises a one-clock error pulse.

On the wire, the bits of both bytes are interleaved: the odd channels come first, then the even channels. The parallel control outputs and diagnostic inputs are indexed by channel. Two reset inputs, a pin reset and a low-supply detector, are combined. Either one clears the control register at once, which turns off every output.

Top module: `oc_spi_port`

## Requirements
- R1: The serial clock idles low. The port moves a new bit onto `miso_o` only on a rising serial-clock edge, and samples `mosi` only on a falling edge.
- R2: Both directions carry the most significant wire bit first.
- R3: Wire bit 7 down to wire bit 0 carries channels 1, 3, 5, 7, 0, 2, 4, 6. This order applies to both bytes. Bit i of `ctrl_o` and bit i of `diag_i` belong to channel i.
- R4: When the chip enable falls, `diag_i` is loaded for shifting out and `miso_oe` goes to 1. `miso_o` stays 0 until the first rising serial-clock edge.
- R5: When the chip enable rises, `ctrl_o` takes the shifted-in byte only if the count of falling serial-clock edges in the frame is a nonzero multiple of 8. Otherwise `ctrl_o` is unchanged. The update is visible on the third rising system-clock edge after the pin changes.
- R6: In a frame longer than 8 bits, the last 8 bits received are the ones committed. After the first 8 bits, `miso_o` sends back the bits received earlier in the same frame.
- R7: While the chip enable is high, `miso_oe` is 0 and serial-clock and data activity changes neither `ctrl_o` nor the bit count of the next frame.
- R8: When either `rst_n` or `lvr_n` is low, `ctrl_o` is cleared at once (asynchronously) and `miso_oe` is 0.
- R9: `frame_err_o` is 1 for exactly one clock when a frame ends with a count that is zero or not a multiple of 8. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low pin reset |
| lvr_n | input | 1 | Active-low low-supply reset, combined with rst_n |
| sck | input | 1 | Serial clock, idles low |
| ce_n | input | 1 | Active-low chip enable |
| mosi | input | 1 | Serial command data in |
| diag_i | input | 8 | Channel status, bit i = channel i |
| miso_o | output | 1 | Serial diagnostic data out |
| miso_oe | output | 1 | Output enable for the external MISO driver |
| ctrl_o | output | 8 | Output control register, bit i = channel i |
| frame_err_o | output | 1 | One-clock pulse when a frame ends with a bad count |

## Verification
The assertions check the following on every cycle:
- The control register changes only when the chip enable rises with a valid count.
- The error pulse lasts one clock.
- The diagnostic capture and driver enable follow the falling chip enable.
- The shift register stays still while the port is deselected.

Some behaviour can only be shown by the bench's frames:
- The interleaved channel order.
- The exact bit sequence on `miso_o`.
- That a 16-bit frame sends back its first byte.
- That short and empty frames are rejected.
- That serial-clock activity while the port is deselected leaves the next frame unchanged.

// File: rtl/oc_pkg.sv
package oc_pkg;
    parameter int unsigned OC_LANES = 8;
    parameter int unsigned OC_SYNC_STAGES = 2;

    typedef struct packed {
        logic sel_fall;
        logic sel_rise;
        logic clk_rise;
        logic clk_fall;
    } oc_evt_t;
endpackage

// File: rtl/oc_sync.sv
module oc_sync #(
    parameter int unsigned W = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) begin
                    stg_q[g] <= RST_VAL;
                end else if (g == 0) begin
                    stg_q[g] <= d;
                end else begin
                    stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/oc_interleave.sv
module oc_interleave #(
    parameter int unsigned N = 8,
    parameter bit TO_WIRE = 1'b1
) (
    input  logic [N-1:0] in_bits,
    output logic [N-1:0] out_bits
);
    localparam int unsigned HALF = N / 2;

    genvar k;
    generate
        for (k = 0; k < HALF; k++) begin : g_pair
            if (TO_WIRE) begin : g_fwd
                assign out_bits[N-1-k]    = in_bits[2*k+1];
                assign out_bits[HALF-1-k] = in_bits[2*k];
            end else begin : g_rev
                assign out_bits[2*k+1] = in_bits[N-1-k];
                assign out_bits[2*k]   = in_bits[HALF-1-k];
            end
        end
    endgenerate
endmodule

// File: rtl/oc_spi_port.sv
module oc_spi_port #(
    parameter int unsigned N = oc_pkg::OC_LANES,
    parameter int unsigned SYNC = oc_pkg::OC_SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lvr_n,
    input  logic         sck,
    input  logic         ce_n,
    input  logic         mosi,
    input  logic [N-1:0] diag_i,
    output logic         miso_o,
    output logic         miso_oe,
    output logic [N-1:0] ctrl_o,
    output logic         frame_err_o
);
    import oc_pkg::*;

    localparam int unsigned CW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [N-1:0]  sh;
        logic [CW-1:0] cnt;
        logic          any;
        logic          miso;
        logic          oe;
        logic [N-1:0]  ctrl;
        logic          err;
        logic          sck_p;
        logic          ce_p;
    } st_t;

    localparam st_t ST_RST = '{sh: '0, cnt: '0, any: 1'b0, miso: 1'b0, oe: 1'b0,
                               ctrl: '0, err: 1'b0, sck_p: 1'b0, ce_p: 1'b1};

    logic    arst_n;
    logic    sck_s, ce_s, mosi_s;
    logic [N-1:0] diag_w, sh_chan;
    oc_evt_t evt;
    st_t     s_d, s_q;

    assign arst_n = rst_n & lvr_n;

    oc_sync #(.W(3), .STAGES(SYNC), .RST_VAL(3'b010)) i_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .d      ({sck, ce_n, mosi}),
        .q      ({sck_s, ce_s, mosi_s})
    );

    oc_interleave #(.N(N), .TO_WIRE(1'b1)) i_to_wire (
        .in_bits  (diag_i),
        .out_bits (diag_w)
    );

    oc_interleave #(.N(N), .TO_WIRE(1'b0)) i_to_chan (
        .in_bits  (s_q.sh),
        .out_bits (sh_chan)
    );

    always_comb begin
        evt.sel_fall = s_q.ce_p & ~ce_s;
        evt.sel_rise = ~s_q.ce_p & ce_s;
        evt.clk_rise = ~ce_s & ~s_q.ce_p & ~s_q.sck_p & sck_s;
        evt.clk_fall = ~ce_s & ~s_q.ce_p & s_q.sck_p & ~sck_s;
    end

    always_comb begin
        s_d       = s_q;
        s_d.sck_p = sck_s;
        s_d.ce_p  = ce_s;
        s_d.err   = 1'b0;
        if (evt.sel_fall) begin
            s_d.sh   = diag_w;
            s_d.cnt  = '0;
            s_d.any  = 1'b0;
            s_d.miso = 1'b0;
            s_d.oe   = 1'b1;
        end else if (evt.sel_rise) begin
            s_d.oe = 1'b0;
            if (s_q.any && (s_q.cnt == '0)) begin
                s_d.ctrl = sh_chan;
            end else begin
                s_d.err = 1'b1;
            end
        end else begin
            if (evt.clk_rise) begin
                s_d.miso = s_q.sh[N-1];
            end
            if (evt.clk_fall) begin
                s_d.sh  = {s_q.sh[N-2:0], mosi_s};
                s_d.cnt = s_q.cnt + CW'(1);
                s_d.any = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            s_q <= ST_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign miso_o      = s_q.miso;
    assign miso_oe     = s_q.oe;
    assign ctrl_o      = s_q.ctrl;
    assign frame_err_o = s_q.err;

    AST_CTRL_ONLY_ON_SEL_RISE: assert property (@(posedge clk) disable iff (!arst_n)
        !evt.sel_rise |=> $stable(ctrl_o)); // R5
    AST_BAD_COUNT_HOLDS_CTRL: assert property (@(posedge clk) disable iff (!arst_n)
        (evt.sel_rise && (!s_q.any || (s_q.cnt != '0))) |=> ($stable(ctrl_o) && frame_err_o)); // R9
    AST_ERR_ONE_CLOCK: assert property (@(posedge clk) disable iff (!arst_n)
        frame_err_o |=> !frame_err_o); // R9
    AST_LOAD_ON_SEL_FALL: assert property (@(posedge clk) disable iff (!arst_n)
        evt.sel_fall |=> (miso_oe && !miso_o && (s_q.sh == $past(diag_w)))); // R4
    AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!arst_n)
        (ce_s && s_q.ce_p) |=> ($stable(s_q.sh) && !miso_oe)); // R7
    AST_MISO_ON_RISE_ONLY: assert property (@(posedge clk) disable iff (!arst_n)
        (!evt.clk_rise && !evt.sel_fall) |=> $stable(miso_o)); // R1
endmodule

// File: tb/test_oc_spi_port.sv
module test_oc_spi_port;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n, lvr_n, sck, ce_n, mosi;
    logic [7:0] diag_i;
    logic miso_o, miso_oe, frame_err_o;
    logic [7:0] ctrl_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit mon_on = 0;
    bit settle = 0;
    bit in_frame = 0;
    logic [7:0] exp_ctrl = 8'h00;
    bit exp_q[$];
    bit sent_q[$];
    int order[8] = '{1, 3, 5, 7, 0, 2, 4, 6};

    always #10 clk = ~clk;

    oc_spi_port i_oc_spi_port (
        .clk(clk), .rst_n(rst_n), .lvr_n(lvr_n), .sck(sck), .ce_n(ce_n), .mosi(mosi),
        .diag_i(diag_i), .miso_o(miso_o), .miso_oe(miso_oe), .ctrl_o(ctrl_o),
        .frame_err_o(frame_err_o)
    );

    function automatic logic [7:0] to_wire(input logic [7:0] ch);
        logic [7:0] w;
        for (int k = 0; k < 8; k++) w[7-k] = ch[order[k]];
        return w;
    endfunction

    function automatic logic [7:0] to_chan(input logic [7:0] w);
        logic [7:0] c;
        for (int k = 0; k < 8; k++) c[order[k]] = w[7-k];
        return c;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (mon_on && !settle) begin
            chk("R5 ctrl hold", ctrl_o, exp_ctrl);
            chk("R9 no err", frame_err_o, 1'b0);
            if (!in_frame) chk("R7 miso_oe idle", miso_oe, 1'b0);
        end
    end

    task automatic start_frame(input logic [7:0] diag);
        logic [7:0] w;
        @(negedge clk);
        diag_i = diag;
        w = to_wire(diag);
        exp_q.delete();
        sent_q.delete();
        for (int b = 7; b >= 0; b--) exp_q.push_back(w[b]);
        in_frame = 1;
        ce_n = 1'b0;
        ticks(4);
        chk("R4 miso_oe on", miso_oe, 1'b1);
        chk("R4 miso idle 0", miso_o, 1'b0);
    endtask

    task automatic send_bit(input bit b);
        bit e;
        mosi = b;
        sck = 1'b1;
        ticks(HALF);
        e = exp_q.pop_front();
        chk("R1 R2 R6 miso bit", miso_o, e);
        sck = 1'b0;
        ticks(HALF);
        exp_q.push_back(b);
        sent_q.push_back(b);
    endtask

    task automatic send_chan_byte(input logic [7:0] ch);
        logic [7:0] w;
        w = to_wire(ch);
        for (int b = 7; b >= 0; b--) send_bit(w[b]);
    endtask

    task automatic end_frame();
        int n;
        bit ok;
        logic [7:0] w;
        logic [7:0] nxt;
        n = sent_q.size();
        ok = (n > 0) && (n % 8 == 0);
        w = 8'h00;
        if (ok) for (int k = 0; k < 8; k++) w[7-k] = sent_q[n-8+k];
        nxt = ok ? to_chan(w) : exp_ctrl;
        settle = 1;
        ce_n = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R5 ctrl before update", ctrl_o, exp_ctrl);
        @(negedge clk);
        chk("R5 R3 ctrl after CE rise", ctrl_o, nxt);
        chk("R9 err pulse", frame_err_o, !ok);
        chk("R7 miso_oe off", miso_oe, 1'b0);
        @(negedge clk);
        chk("R9 err one clock", frame_err_o, 1'b0);
        exp_ctrl = nxt;
        in_frame = 0;
        settle = 0;
        ticks(3);
    endtask

    task automatic pulse_reset(input bit use_lvr);
        @(negedge clk);
        settle = 1;
        if (use_lvr) lvr_n = 1'b0; else rst_n = 1'b0;
        #2;
        chk("R8 ctrl cleared async", ctrl_o, 8'h00);
        chk("R8 miso_oe off", miso_oe, 1'b0);
        exp_ctrl = 8'h00;
        ticks(2);
        lvr_n = 1'b1;
        rst_n = 1'b1;
        ticks(4);
        settle = 0;
    endtask

    initial begin
        rst_n = 1'b0; lvr_n = 1'b1; sck = 1'b0; ce_n = 1'b1; mosi = 1'b0; diag_i = 8'h00;
        #5;
        chk("R8 reset ctrl", ctrl_o, 8'h00);
        chk("R8 reset oe", miso_oe, 1'b0);
        chk("R9 reset err", frame_err_o, 1'b0);
        ticks(3);
        rst_n = 1'b1;
        ticks(4);
        mon_on = 1;

        // R3: single-channel bytes expose the interleaved order
        start_frame(8'h02); send_chan_byte(8'h01); end_frame();
        start_frame(8'h01); send_chan_byte(8'h80); end_frame();
        start_frame(8'h3A); send_chan_byte(8'h5C); end_frame();
        start_frame(8'hC5); send_chan_byte(8'hFF); end_frame();

        // R5 R9: seven bits keeps the old value
        start_frame(8'h0F); for (int i = 0; i < 7; i++) send_bit(i[0]); end_frame();
        // R9: empty frame
        start_frame(8'hF0); end_frame();

        // R6: sixteen bits, second byte echoes the first, last byte commits
        start_frame(8'h96); send_chan_byte(8'h11); send_chan_byte(8'h6B); end_frame();

        // R7: serial clock while deselected has no effect
        for (int i = 0; i < 3; i++) begin
            mosi = i[0]; sck = 1'b1; ticks(HALF); sck = 1'b0; ticks(HALF);
        end
        start_frame(8'h55); send_chan_byte(8'hA4); end_frame();

        // R8: both reset sources
        pulse_reset(1'b0);
        start_frame(8'h00); send_chan_byte(8'h7E); end_frame();
        pulse_reset(1'b1);
        start_frame(8'hAA); send_chan_byte(8'h33); end_frame();

        mon_on = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule